// File: doc/BRIEF.md
# Amplitude-Shaping Power-Ramp Sequencer

This block sets the 8-bit drive level of a transmitter's power amplifier. It reads that level from a small table of power words. A level index walks through the table one position per step. The step lasts a programmable number of clocks.

The same walk serves three uses:
- In constant-envelope mode, the index climbs from entry 0 to a programmable top entry when a burst starts, stays there, and falls back to entry 0 when the burst ends.
- In amplitude-keyed mode, each data bit taken on a strobe picks the target. A one selects the top entry and a zero selects entry 0. The output therefore slides between the two levels through the entries in between.
- With the top set to 1, the same rule gives on-off keying between entry 0 and entry 1. With the top set to 0, the output is a single fixed level.

The table is written only while the transmitter is quiet. A sleep request wipes every entry except entry 0.

Top module: `ask_ramp_seq`

## Requirements
- R1: After reset every table entry is 0x00, the level index is 0, `pwr_level` is 0x00 and `ramp_done` is 1 while `tx_en` is 0.
- R2: With `tx_en` high and `mod_ask` 0 (constant envelope), the index rises by exactly one every STEP_DIV clocks from 0 to `top_idx` and then holds. `pwr_level` always shows the entry at the current index.
- R3: After `tx_en` falls, the index drops by one every STEP_DIV clocks down to 0. `ramp_done` is 1 exactly when `tx_en` is 0 and the index is 0, and then stays 1 until `tx_en` rises.
- R4: With `mod_ask` 1, a clock with `bit_stb` high stores `bit_val`. The stored bit takes effect on the following clock: a 1 sets the target to `top_idx` and a 0 sets it to 0. The index walks toward the target one entry per step. The stored bit clears while `tx_en` is 0.
- R5: With `mod_ask` 1 and `top_idx` 1, a 0 bit settles on entry 0 and a 1 bit settles on entry 1 (on-off keying).
- R6: With `top_idx` 0, the output stays on entry 0 for the whole burst in either mode.
- R7: A write (`wr_en` high) stores `wr_data` at `wr_idx` only when `tx_en` is 0, the index is 0 and `sleep` is 0. Otherwise it is ignored.
- R8: Each clock with `sleep` high sets entries 1 to 2**IDX_W-1 to 0x00 and leaves entry 0 unchanged. Those entries keep reading 0x00 after wake until they are rewritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Burst active |
| mod_ask | input | 1 | 1: amplitude-keyed, 0: constant envelope |
| bit_stb | input | 1 | Data bit strobe |
| bit_val | input | 1 | Data bit taken on strobe |
| top_idx | input | IDX_W | Highest table entry used |
| wr_en | input | 1 | Table write request |
| wr_idx | input | IDX_W | Table write address |
| wr_data | input | LVL_W | Table write value |
| sleep | input | 1 | Sleep request, clears entries above 0 |
| pwr_level | output | LVL_W | Current power word |
| ramp_done | output | 1 | Burst ended and output back on entry 0 |

## Verification
The bench builds the block with IDX_W=3, LVL_W=8 and STEP_DIV=2. A step of two clocks selects the counting variant of the step timer. It also makes the cycle in which a step is pending observable, so a target change part-way through a step can be tested. This happens when a new bit is stored at the top of an amplitude-keyed ramp. The table entries are written as distinct values, so every index step shows up as a different `pwr_level`. Writes during a burst, during the down-ramp and during sleep are each followed by a ramp that reads back the entry they tried to change.

// File: rtl/ask_ramp_pkg.sv
package ask_ramp_pkg;
   typedef enum logic {
      MOD_CONST = 1'b0,
      MOD_ASK   = 1'b1
   } mod_e;

   // Step toward a target by one index.
   function automatic logic [7:0] step_toward(input logic [7:0] cur, input logic [7:0] tgt);
      if (cur < tgt) return cur + 8'd1;
      else if (cur > tgt) return cur - 8'd1;
      else return cur;
   endfunction
endpackage

// File: rtl/ask_ramp_table.sv
module ask_ramp_table #(
   parameter int IDX_W = 3,
   parameter int LVL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sleep,
   input  logic             wr_ok,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LVL_W-1:0] wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [LVL_W-1:0] rd_data
);
   localparam int DEPTH = 1 << IDX_W;

   logic [LVL_W-1:0] ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic [LVL_W-1:0] ent_q;
      logic             hit;
      assign hit = wr_ok && (wr_idx == IDX_W'(e));
      if (e == 0) begin : g_keep
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   ent_q <= '0;
            else if (hit) ent_q <= wr_data;
         end
      end else begin : g_lose
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      ent_q <= '0;
            else if (sleep)  ent_q <= '0;
            else if (hit)    ent_q <= wr_data;
         end
      end
      assign ent[e] = ent_q;
   end

   assign rd_data = ent[rd_idx];
endmodule

// File: rtl/ask_ramp_step_timer.sv
module ask_ramp_step_timer #(
   parameter int STEP_DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CNT_W = (STEP_DIV > 1) ? $clog2(STEP_DIV) : 1;

   if (STEP_DIV == 1) begin : g_direct
      assign tick = run;
   end else begin : g_count
      logic [CNT_W-1:0] cnt_q;
      logic             last;
      assign last = (cnt_q == CNT_W'(STEP_DIV - 1));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (!run)  cnt_q <= '0;
         else if (last)  cnt_q <= '0;
         else            cnt_q <= cnt_q + CNT_W'(1);
      end
      assign tick = run && last;
   end
endmodule

// File: rtl/ask_ramp_walker.sv
module ask_ramp_walker
   import ask_ramp_pkg::*;
#(
   parameter int IDX_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  mod_e             mode,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic [IDX_W-1:0] top_idx,
   input  logic             tick,
   output logic             run,
   output logic [IDX_W-1:0] idx
);
   logic             sym_q;
   logic [IDX_W-1:0] idx_q;
   logic [IDX_W-1:0] target;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sym_q <= 1'b0;
      else if (!tx_en)  sym_q <= 1'b0;
      else if (bit_stb) sym_q <= bit_val;
   end

   always_comb begin
      if (!tx_en)               target = '0;
      else if (mode == MOD_ASK) target = sym_q ? top_idx : '0;
      else                      target = top_idx;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    idx_q <= '0;
      else if (tick) idx_q <= IDX_W'(step_toward(8'(idx_q), 8'(target)));
   end

   assign run = (target != idx_q);
   assign idx = idx_q;
endmodule

// File: rtl/ask_ramp_seq.sv
module ask_ramp_seq
   import ask_ramp_pkg::*;
#(
   parameter int IDX_W    = 3,
   parameter int LVL_W    = 8,
   parameter int STEP_DIV = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_en,
   input  logic             mod_ask,
   input  logic             bit_stb,
   input  logic             bit_val,
   input  logic [IDX_W-1:0] top_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [LVL_W-1:0] wr_data,
   input  logic             sleep,
   output logic [LVL_W-1:0] pwr_level,
   output logic             ramp_done
);
   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("IDX_W must lie in 1..8");
   end
   if (LVL_W < 1) begin : g_bad_lvl
      $error("LVL_W must be at least 1");
   end
   if (STEP_DIV < 1) begin : g_bad_div
      $error("STEP_DIV must be at least 1");
   end

   logic             run;
   logic             tick;
   logic [IDX_W-1:0] cur_idx;
   logic             wr_ok;
   mod_e             mode;

   assign mode  = mod_e'(mod_ask);
   assign wr_ok = wr_en && !sleep && !tx_en && (cur_idx == '0);

   ask_ramp_step_timer #(.STEP_DIV(STEP_DIV)) i_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (run),
      .tick  (tick)
   );

   ask_ramp_walker #(.IDX_W(IDX_W)) i_walker (
      .clk     (clk),
      .rst_n   (rst_n),
      .tx_en   (tx_en),
      .mode    (mode),
      .bit_stb (bit_stb),
      .bit_val (bit_val),
      .top_idx (top_idx),
      .tick    (tick),
      .run     (run),
      .idx     (cur_idx)
   );

   ask_ramp_table #(.IDX_W(IDX_W), .LVL_W(LVL_W)) i_table (
      .clk     (clk),
      .rst_n   (rst_n),
      .sleep   (sleep),
      .wr_ok   (wr_ok),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .rd_idx  (cur_idx),
      .rd_data (pwr_level)
   );

   assign ramp_done = !tx_en && (cur_idx == '0);
endmodule

// File: rtl/ask_ramp_seq_chk.sv
module ask_ramp_seq_chk #(
   parameter int IDX_W = 3,
   parameter int LVL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tx_en,
   input logic             mod_ask,
   input logic [IDX_W-1:0] top_idx,
   input logic             sleep,
   input logic [IDX_W-1:0] cur_idx,
   input logic [LVL_W-1:0] pwr_level,
   input logic             ramp_done
);
   AST_UNIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_idx == $past(cur_idx)) || (cur_idx == $past(cur_idx) + IDX_W'(1)) ||
      (cur_idx + IDX_W'(1) == $past(cur_idx)));                                  // R2

   AST_TOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && !mod_ask && !$past(mod_ask) && $stable(top_idx) &&
       $past(cur_idx) == top_idx) |-> (cur_idx == top_idx));                    // R2

   AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(ramp_done) && !tx_en) |-> ramp_done);                               // R3

   AST_ZERO_TOP_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      (top_idx == '0 && $past(top_idx) == '0 && $past(cur_idx) == '0) |-> (cur_idx == '0)); // R6

   AST_WRITE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en && $past(tx_en) && !$past(sleep) && $stable(cur_idx)) |-> $stable(pwr_level)); // R7
endmodule

bind ask_ramp_seq ask_ramp_seq_chk #(.IDX_W(IDX_W), .LVL_W(LVL_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tx_en     (tx_en),
   .mod_ask   (mod_ask),
   .top_idx   (top_idx),
   .sleep     (sleep),
   .cur_idx   (cur_idx),
   .pwr_level (pwr_level),
   .ramp_done (ramp_done)
);

// File: tb/test_ask_ramp_seq.sv
module test_ask_ramp_seq;
   localparam int CLK_PERIOD = 10;
   localparam int IDX_W = 3;
   localparam int LVL_W = 8;
   localparam int STEP_DIV = 2;
   localparam int NVEC = 35;

   // {tx_en, mod_ask, bit_stb, bit_val, top_idx[2:0], exp_done, exp_pwr[7:0]}
   localparam logic [15:0] VEC [NVEC] = '{
      16'h8611, 16'h8622, 16'h8622, 16'h8633, 16'h8633, 16'h8644, 16'h8644,
      16'h0644, 16'h0633, 16'h0633, 16'h0622, 16'h0622, 16'h0711, 16'h0711,
      16'hF411, 16'hC411, 16'hC422, 16'hC422, 16'hC433, 16'hC433,
      16'hE433, 16'hC433, 16'hC422, 16'hC422, 16'hC411, 16'hC411,
      16'hF211, 16'hC211, 16'hC222, 16'hC222, 16'h4222, 16'h4311,
      16'h8011, 16'h8011, 16'h0111
   };

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             tx_en = 1'b0, mod_ask = 1'b0, bit_stb = 1'b0, bit_val = 1'b0;
   logic [IDX_W-1:0] top_idx = '0, wr_idx = '0;
   logic             wr_en = 1'b0, sleep = 1'b0;
   logic [LVL_W-1:0] wr_data = '0;
   logic [LVL_W-1:0] pwr_level;
   logic             ramp_done;

   int n_cmp = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ask_ramp_seq #(.IDX_W(IDX_W), .LVL_W(LVL_W), .STEP_DIV(STEP_DIV)) i_ask_ramp_seq (
      .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .mod_ask(mod_ask), .bit_stb(bit_stb),
      .bit_val(bit_val), .top_idx(top_idx), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_data(wr_data), .sleep(sleep), .pwr_level(pwr_level), .ramp_done(ramp_done)
   );

   task automatic check(input string req, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic put(input logic [IDX_W-1:0] a, input logic [LVL_W-1:0] d);
      wr_en = 1'b1; wr_idx = a; wr_data = d;
      cyc(1);
      wr_en = 1'b0;
   endtask

   function automatic string vec_req(input int i);
      if (i < 7)       return "R2";
      else if (i < 14) return "R3";
      else if (i < 26) return "R4";
      else if (i < 32) return "R5";
      else             return "R6";
   endfunction

   initial begin
      #(CLK_PERIOD * 200000);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      cyc(3);
      // R1: reset state
      check("R1 level", int'(pwr_level), 0);
      check("R1 done", int'(ramp_done), 1);
      rst_n = 1'b1;
      cyc(1);
      for (int e = 0; e < 8; e++) put(IDX_W'(e), LVL_W'(8'h11 * (e + 1)));
      check("R7 write idle", int'(pwr_level), 8'h11);

      for (int i = 0; i < NVEC; i++) begin
         {tx_en, mod_ask, bit_stb, bit_val, top_idx} = VEC[i][15:9];
         cyc(1);
         check(vec_req(i), int'(pwr_level), int'(VEC[i][7:0]));
         check(vec_req(i), int'(ramp_done), int'(VEC[i][8]));
      end
      tx_en = 1'b0; mod_ask = 1'b0; bit_stb = 1'b0; bit_val = 1'b0;

      // R7: write during burst ignored
      tx_en = 1'b1; top_idx = 3'd0;
      put(3'd0, 8'hEE);
      tx_en = 1'b0;
      cyc(1);
      check("R7 burst write", int'(pwr_level), 8'h11);

      // R7: write during down-ramp ignored
      tx_en = 1'b1; top_idx = 3'd1;
      cyc(2);
      check("R2 ramp to 1", int'(pwr_level), 8'h22);
      tx_en = 1'b0;
      put(3'd1, 8'hEE);
      check("R7 ramp-down write", int'(pwr_level), 8'h22);
      cyc(1);
      check("R3 back to 0", int'(ramp_done), 1);
      tx_en = 1'b1;
      cyc(2);
      check("R7 entry 1 kept", int'(pwr_level), 8'h22);
      tx_en = 1'b0;
      cyc(2);

      // R8: sleep clears entries above 0; write during sleep ignored
      sleep = 1'b1;
      put(3'd0, 8'h77);
      sleep = 1'b0;
      tx_en = 1'b1; top_idx = 3'd2;
      cyc(1);
      check("R8 entry 0 kept", int'(pwr_level), 8'h11);
      cyc(1);
      check("R8 entry 1 cleared", int'(pwr_level), 8'h00);
      cyc(2);
      check("R8 entry 2 cleared", int'(pwr_level), 8'h00);
      tx_en = 1'b0;
      cyc(4);
      check("R3 done after ramp", int'(ramp_done), 1);
      check("R8 entry 0 at rest", int'(pwr_level), 8'h11);

      // R7: rewrite after wake takes effect
      put(3'd1, 8'h5A);
      tx_en = 1'b1; top_idx = 3'd1;
      cyc(2);
      check("R7 write after wake", int'(pwr_level), 8'h5A);
      tx_en = 1'b0;
      cyc(3);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule